// File: doc/BRIEF.md
# Low-latency first-word-fall-through FIFO

This block is a small single-clock FIFO whose oldest word is always presented on the read side without a request cycle. A producer offers words on a valid/ready write stream and a consumer takes them from a valid/ready read stream. The consumer sees the head word as soon as `out_valid` is high and removes it by raising `out_ready`. A removal costs no extra cycle.

The design keeps the read side shallow. `out_data` comes from a two-way mux. One leg is a staging register loaded from the storage array, and the other is a bypass register loaded straight from `in_data`. A single dedicated register drives the mux select. `out_valid` is the OR of two registered valid bits, one per leg. The full condition is registered too, and an `out_ready` in the same cycle lifts it.

Back-pressure rules: a producer should offer a word only while `in_ready` is high. Total capacity is DEPTH+1 words, made of DEPTH array words plus the head slot. `in_ready` already falls when DEPTH words are held, so one further word is still kept. This lets a producer that sees `in_ready` one cycle late lose nothing. A word offered while DEPTH+1 words are held and `out_ready` is low is discarded. `out_ready` may be raised at any time, and it has no effect while `out_valid` is low.

Top module: `lowlat_fifo`

## Requirements
- R1: After a synchronous reset with `rst` high at a clock edge, `out_valid` is 0 and `in_ready` is 1.
- R2: A word accepted while the FIFO is empty appears on `out_data` with `out_valid` high at the very next clock edge.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change at the next edge.
- R4: While DEPTH or more words are held and `out_ready` is low, `in_ready` is 0. With fewer than DEPTH words held, `in_ready` is 1.
- R5: Whenever `out_ready` is high, `in_ready` is 1. A read in the same cycle releases the full condition, so a word is accepted even when the FIFO holds DEPTH+1 words.
- R6: With `in_ready` low, a word offered while fewer than DEPTH+1 words are held is still stored and later read out in order.
- R7: A word offered while DEPTH+1 words are held and `out_ready` is low is discarded. The occupancy and the stored words are unchanged.
- R8: A read request while `out_valid` is 0 has no effect. If nothing is written, `out_valid` stays 0 at the next edge.
- R9: A write and a read request in the same cycle on an empty FIFO store the word. The FIFO then holds exactly that one word, which is shown at the next edge.
- R10: Words leave in exactly the order they were accepted, under any mix of writes and reads over the full capacity.
- R11: A reset applied while data is held empties the FIFO. Words accepted after the reset come out in order, and no word from before the reset is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | W | Word offered by producer |
| in_ready | output | 1 | FIFO below full threshold, or read in same cycle |
| out_valid | output | 1 | Head word present (not empty) |
| out_data | output | W | Current head word |
| out_ready | input | 1 | Consumer removes head word this cycle |

## Verification
The hardest states to reach are the ones at the top of the occupancy range. The spare slot above the full threshold and the discard of a word at DEPTH+1 both need a producer that keeps writing after `in_ready` has fallen, which a well-behaved stream source never does. The bench therefore drives `in_valid` without regard to `in_ready`. For every starting occupancy from 0 to DEPTH+1, it fills the FIFO to that level and then applies each of the four write/read combinations once. After that it drains the FIFO and compares every word against a queue model. Random traffic at several densities then mixes all the transitions, including a reset with data inside.

// File: rtl/lowlat_fifo_pkg.sv
package lowlat_fifo_pkg;
  // which register currently feeds the read-side mux
  typedef enum logic {
    HEAD_BYPASS = 1'b0,
    HEAD_STAGED = 1'b1
  } head_src_e;
endpackage

// File: rtl/lff_store.sv
module lff_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         arr_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW-1:0] fill_q;

  // one write-enabled word register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr_q == PW'(i))) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      fill_q <= fill_q + AW'(wr_en) - AW'(rd_en);
    end
  end

  assign rd_data   = mem[rd_ptr_q];
  assign arr_empty = (fill_q == '0);
endmodule

// File: rtl/lff_head.sv
module lff_head
  import lowlat_fifo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_byp,
  input  logic         load_stg,
  input  logic         drop,
  input  logic [W-1:0] byp_din,
  input  logic [W-1:0] stg_din,
  output logic [W-1:0] head_data,
  output logic         head_valid
);
  logic [W-1:0] byp_q, stg_q;
  logic         byp_v_q, stg_v_q;
  head_src_e    sel_q;

  always_ff @(posedge clk) begin
    if (load_stg) stg_q <= stg_din;
    if (load_byp) byp_q <= byp_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_v_q <= 1'b0;
      stg_v_q <= 1'b0;
      sel_q   <= HEAD_BYPASS;
    end else if (load_stg) begin
      stg_v_q <= 1'b1;
      byp_v_q <= 1'b0;
      sel_q   <= HEAD_STAGED;
    end else if (load_byp) begin
      byp_v_q <= 1'b1;
      stg_v_q <= 1'b0;
      sel_q   <= HEAD_BYPASS;
    end else if (drop) begin
      byp_v_q <= 1'b0;
      stg_v_q <= 1'b0;
    end
  end

  assign head_data  = (sel_q == HEAD_STAGED) ? stg_q : byp_q;
  assign head_valid = byp_v_q | stg_v_q;
endmodule

// File: rtl/lff_ctrl.sv
module lff_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic head_valid,
  input  logic arr_empty,
  output logic wr_arr,
  output logic rd_arr,
  output logic load_byp,
  output logic drop,
  output logic in_ready,
  output logic [$clog2(DEPTH+2)-1:0] occ
);
  localparam int CAP = DEPTH + 1;
  localparam int THR = DEPTH;
  localparam int CW  = $clog2(DEPTH + 2);

  logic [CW-1:0] occ_q, occ_d;
  logic          full_q;
  logic          pop, accept, head_free;

  assign pop       = out_ready & head_valid;
  assign accept    = in_valid & ((occ_q != CW'(CAP)) | pop);
  assign head_free = ~head_valid | pop;
  assign rd_arr    = head_free & ~arr_empty;
  assign load_byp  = head_free & arr_empty & accept;
  assign wr_arr    = accept & ~load_byp;
  assign drop      = head_free & ~rd_arr & ~load_byp;
  assign occ_d     = occ_q + CW'(accept) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= '0;
      full_q <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      full_q <= (occ_d >= CW'(THR));
    end
  end

  assign in_ready = ~full_q | out_ready;
  assign occ      = occ_q;
endmodule

// File: rtl/lowlat_fifo.sv
module lowlat_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int CW = $clog2(DEPTH + 2);

  logic         wr_arr, rd_arr, load_byp, drop, arr_empty;
  logic [W-1:0] arr_dout;
  logic [CW-1:0] occ_w;

  lff_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .head_valid(out_valid), .arr_empty(arr_empty),
    .wr_arr(wr_arr), .rd_arr(rd_arr), .load_byp(load_byp), .drop(drop),
    .in_ready(in_ready), .occ(occ_w)
  );

  lff_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_arr), .wr_data(in_data),
    .rd_en(rd_arr), .rd_data(arr_dout), .arr_empty(arr_empty)
  );

  lff_head #(.W(W)) head_i (
    .clk(clk), .rst(rst), .load_byp(load_byp), .load_stg(rd_arr),
    .drop(drop), .byp_din(in_data), .stg_din(arr_dout),
    .head_data(out_data), .head_valid(out_valid)
  );
endmodule

// File: rtl/lowlat_fifo_chk.sv
module lowlat_fifo_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [W-1:0]               in_data,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic [W-1:0]               out_data,
  input logic                       out_ready,
  input logic [$clog2(DEPTH+2)-1:0] occ
);
  localparam int CW  = $clog2(DEPTH + 2);
  localparam int CAP = DEPTH + 1;

  // R2
  a_r2_fall_through: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
  // R3
  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4
  a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (occ >= CW'(DEPTH) && !out_ready) |-> !in_ready);
  // R5
  a_r5_read_releases: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
  // R7
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(CAP) && !out_ready) |=> (occ == CW'(CAP) && $stable(out_data)));
  // R7
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(CAP));
  // R8
  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_valid) |=> !out_valid);
  // R10
  a_r10_valid_tracks_occ: assert property (@(posedge clk) disable iff (rst)
    out_valid == (occ != '0));
endmodule

bind lowlat_fifo lowlat_fifo_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .occ(occ_w)
);

// File: tb/lowlat_fifo_tb_top.sv
module lowlat_fifo_tb_top;
  localparam int W     = 8;
  localparam int DEPTH = 4;
  localparam int CAP   = DEPTH + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid, out_ready = 1'b0;
  logic [W-1:0] out_data;

  int total = 0;
  int bad   = 0;
  int q[$];
  logic [W-1:0] seq = 8'h11;
  logic         prev_hold = 1'b0;
  logic [W-1:0] prev_data = '0;
  logic         done = 1'b0;

  always #5 clk = ~clk;

  lowlat_fifo #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    prev_hold = 1'b0;
    #1;
    check(out_valid == 1'b0, tag, out_valid, 0);
    check(in_ready == 1'b1, tag, in_ready, 1);
  endtask

  // one cycle: drive, check current outputs against the model, update model
  task automatic step(input bit iv, input bit rd, input string tag);
    bit pop, acc;
    @(negedge clk);
    in_valid = iv; out_ready = rd; in_data = seq;
    #1;
    check(out_valid == (q.size() > 0), tag, out_valid, q.size() > 0);
    if (q.size() > 0) begin
      check(out_data == W'(q[0]), "R10", out_data, q[0]);
      if (prev_hold) check(out_data == prev_data, "R3", out_data, prev_data);
    end
    check(in_ready == ((q.size() < DEPTH) || rd), rd ? "R5" : "R4",
          in_ready, (q.size() < DEPTH) || rd);
    pop = rd && (q.size() > 0);
    acc = iv && ((q.size() < CAP) || pop);
    prev_hold = (q.size() > 0) && !rd;
    prev_data = out_data;
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(int'(seq));
    seq = seq + 8'd7;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() > 0 && n < 3 * CAP) begin
      step(1'b0, 1'b1, tag);
      n++;
    end
    step(1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    string tag;
    do_reset("R1");

    // R2: single word into empty FIFO shows on next edge
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R2");
    drain("R10");

    // sweep: every start occupancy x every write/read combination
    for (int s = 0; s <= CAP; s++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset("R1");
        for (int k = 0; k < s; k++) step(1'b1, 1'b0, (k >= DEPTH) ? "R6" : "R4");
        if (s == 0 && c == 3)               tag = "R9";
        else if (s == 0 && c == 2)          tag = "R8";
        else if (s == CAP && c == 1)        tag = "R7";
        else if (s == DEPTH && c == 1)      tag = "R6";
        else if (s == CAP && c == 3)        tag = "R5";
        else                                tag = "R10";
        step(c[0], c[1], tag);
        step(1'b0, 1'b0, tag);
        drain(tag);
      end
    end

    // random traffic at several densities, with a reset holding data
    lfsr = 16'hACE1;
    for (int d = 0; d < 4; d++) begin
      for (int n = 0; n < 800; n++) begin
        bit iv, rd;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        iv = (lfsr[2:0] > 3'(d + 1));
        rd = (lfsr[6:4] <= 3'(d + 2));
        step(iv, rd, "R10");
        if (d == 2 && n == 400) begin
          do_reset("R11");
          step(1'b0, 1'b1, "R11");
        end
      end
      drain("R10");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule